// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Registers

This block holds the software-visible state for a DMA engine with two channels: one serving a SCSI controller and one serving an Ethernet controller. It has eight 32-bit registers behind a simple word-addressed bus port. Three of them have write side effects:

- **Channel control words (index 0 for SCSI, index 4 for Ethernet).** Every write forces a fixed version tag into the top nibble. Setting the reset-request bit sends a one-cycle reset pulse to the matching peripheral. Clearing the interrupt-enable bit drops that channel's interrupt line.
- **SCSI control word, bit 6.** It follows a store rule of its own.
- **SCSI address register (index 1).** A write to it marks the SCSI control word as loaded.

The SCSI channel takes transfer-complete events on a valid/ready stream. Each event carries a byte count. Accepting an event sets the SCSI pending flag and advances the SCSI address by that count.

The stream rules are as follows:

- An event is consumed on a rising clock edge where both `xfer_valid` and `xfer_ready` are high.
- `xfer_ready` is low in any cycle in which the bus writes index 0 or index 1. In that case the producer holds the event, with the same byte count, until a later cycle accepts it.
- The SCSI interrupt line is driven only by explicit raise and clear strobes. The Ethernet line has its own raise and drop strobes, which leave every register unchanged.

Top module: `twin_dma_csr`

## Requirements
- R1: After reset, indices 0 and 4 read 0xA0000000 and every other index reads zero; both interrupt lines and both reset pulses are low.
- R2: The register index is byte address bits [4:2]. Higher address bits and bits [1:0] are ignored, so any address aliases onto one of the eight registers.
- R3: Any write to index 0 or index 4 stores the written value with bits [31:28] replaced by 0xA.
- R4: For a write to index 0 whose bit 7 is 0, bit 6 behaves as follows. If the written bit 6 is 1, the stored bit 6 is 0. Otherwise, if the whole written word is zero, the stored bit 6 is 1. When bit 7 is 1, the written value is kept as written (apart from R3). Index 4 has no such rule.
- R5: A write to index 0 (or 4) with bit 4 (interrupt enable) at 0 makes the SCSI (or Ethernet) interrupt line low from the next cycle on. A write with bit 4 at 1 leaves the line as it was.
- R6: A write to index 0 (or 4) with bit 7 set drives `scsi_rst_pulse` (or `eth_rst_pulse`) high for exactly the one cycle after the write edge. The other channel's pulse stays low.
- R7: Any write to index 1 sets bit 26 (loaded) of index 0, and leaves the rest of index 0 unchanged.
- R8: An accepted transfer event sets bit 0 (pending) of index 0 and adds `xfer_bytes` to index 1, wrapping modulo 2^32. `xfer_ready` is low while the bus writes index 0 or 1, and nothing is added during that cycle. An accepted event does not move the SCSI interrupt line.
- R9: `scsi_irq_raise` sets bit 0 of index 0 and the SCSI line. `scsi_irq_clear` clears both. When the two strobes come in the same cycle, the clear wins. The raise also wins over the bit 0 value of a bus write in the same cycle.
- R10: `eth_irq_raise` sets the Ethernet line and `eth_irq_drop` clears it. Neither strobe changes any register.
- R11: Indices 2, 3, 5, 6 and 7 are plain storage. Reads have no side effects. `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the addressed register |
| xfer_valid | input | 1 | Transfer-complete event valid |
| xfer_ready | output | 1 | Transfer-complete event ready |
| xfer_bytes | input | XFER_W | Byte count of the event |
| scsi_irq_raise | input | 1 | Raise strobe for the SCSI interrupt |
| scsi_irq_clear | input | 1 | Clear strobe for the SCSI interrupt |
| eth_irq_raise | input | 1 | Raise strobe for the Ethernet interrupt |
| eth_irq_drop | input | 1 | Drop strobe for the Ethernet interrupt |
| scsi_irq | output | 1 | SCSI channel interrupt line |
| eth_irq | output | 1 | Ethernet channel interrupt line |
| scsi_rst_pulse | output | 1 | One-cycle reset to the SCSI peripheral |
| eth_rst_pulse | output | 1 | One-cycle reset to the Ethernet peripheral |

## Verification
The control-word store rule is tried with several write patterns:

- an all-zero word;
- a word with only bit 6 set;
- bits 6 and 7 together;
- a word with a wrong version nibble;
- a nonzero word with bit 6 clear.

These patterns separate the three branches of the bit-6 rule from plain version tagging. The same patterns on index 4 show that the Ethernet channel has no bit-6 rule.

Aliased addresses with high bits set separate the index decode from the full-address decode. Transfer events are tried both alone and colliding with an address-register write, which separates the back-pressure path from a lost or double-counted advance. Raise and clear strobes are tried singly, together, and followed by writes with interrupt enable both set and clear.

// File: rtl/twin_dma_pkg.sv
package twin_dma_pkg;
  localparam int REG_COUNT = 8;
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam logic [3:0] VERSION_TAG = 4'hA;
  localparam int BIT_PEND   = 0;
  localparam int BIT_IE     = 4;
  localparam int BIT_TOGGLE = 6;
  localparam int BIT_RSTREQ = 7;
  localparam int BIT_LOADED = 26;
  localparam int IDX_SCSI_CTRL = 0;
  localparam int IDX_SCSI_ADDR = 1;
  localparam int IDX_ETH_CTRL  = 4;
  localparam logic [31:0] CTRL_RESET = {VERSION_TAG, 28'h0};

  function automatic logic [31:0] tag_version(input logic [31:0] v);
    return {VERSION_TAG, v[27:0]};
  endfunction
endpackage

// File: rtl/twin_dma_ctrl_reg.sv
module twin_dma_ctrl_reg
  import twin_dma_pkg::*;
#(
  parameter bit TOGGLE_RULE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  input  logic        set_loaded,
  input  logic        set_pend,
  input  logic        clr_pend,
  output logic [31:0] q,
  output logic        rst_pulse
);
  logic [31:0] shaped;
  logic [31:0] nxt;

  generate
    if (TOGGLE_RULE) begin : g_toggle
      always_comb begin
        shaped = wdata;
        if (!wdata[BIT_RSTREQ]) begin
          if (wdata[BIT_TOGGLE])   shaped[BIT_TOGGLE] = 1'b0;
          else if (wdata == '0)    shaped[BIT_TOGGLE] = 1'b1;
        end
      end
    end else begin : g_plain
      assign shaped = wdata;
    end
  endgenerate

  always_comb begin
    nxt = q;
    if (wr_hit)     nxt = tag_version(shaped);
    if (set_loaded) nxt[BIT_LOADED] = 1'b1;
    if (set_pend)   nxt[BIT_PEND] = 1'b1;
    if (clr_pend)   nxt[BIT_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q         <= CTRL_RESET;
      rst_pulse <= 1'b0;
    end else begin
      q         <= nxt;
      rst_pulse <= wr_hit & wdata[BIT_RSTREQ];
    end
  end
endmodule

// File: rtl/twin_dma_addr_reg.sv
module twin_dma_addr_reg #(
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [31:0]       wdata,
  input  logic              adv,
  input  logic [XFER_W-1:0] adv_bytes,
  output logic [31:0]       q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= wdata;
    else if (adv)    q <= q + 32'(adv_bytes);
  end
endmodule

// File: rtl/twin_dma_irq_line.sv
module twin_dma_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic drop,
  output logic line
);
  always_ff @(posedge clk) begin
    if (!rst_n)     line <= 1'b0;
    else if (drop)  line <= 1'b0;
    else if (raise) line <= 1'b1;
  end
endmodule

// File: rtl/twin_dma_csr.sv
module twin_dma_csr
  import twin_dma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [XFER_W-1:0] xfer_bytes,
  input  logic              scsi_irq_raise,
  input  logic              scsi_irq_clear,
  input  logic              eth_irq_raise,
  input  logic              eth_irq_drop,
  output logic              scsi_irq,
  output logic              eth_irq,
  output logic              scsi_rst_pulse,
  output logic              eth_rst_pulse
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0]     idx;
  logic [REG_COUNT-1:0] wr_hit;
  logic [31:0]          regs [REG_COUNT];
  logic                 xfer_fire;
  logic                 unused_addr_bits;

  assign idx = addr[IDX_HI:IDX_LO];
  assign unused_addr_bits = ^{addr[ADDR_W-1:IDX_HI+1], addr[IDX_LO-1:0]};

  always_comb begin
    for (int i = 0; i < REG_COUNT; i++)
      wr_hit[i] = wr_en && (idx == IDX_W'(i));
  end

  assign xfer_ready = !(wr_hit[IDX_SCSI_CTRL] || wr_hit[IDX_SCSI_ADDR]);
  assign xfer_fire  = xfer_valid && xfer_ready;

  generate
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      if (i == IDX_SCSI_CTRL) begin : g_scsi_ctrl
        twin_dma_ctrl_reg #(.TOGGLE_RULE(1'b1)) u_ctrl (
          .clk       (clk),
          .rst_n     (rst_n),
          .wr_hit    (wr_hit[i]),
          .wdata     (wdata),
          .set_loaded(wr_hit[IDX_SCSI_ADDR]),
          .set_pend  (scsi_irq_raise | xfer_fire),
          .clr_pend  (scsi_irq_clear),
          .q         (regs[i]),
          .rst_pulse (scsi_rst_pulse)
        );
      end else if (i == IDX_ETH_CTRL) begin : g_eth_ctrl
        twin_dma_ctrl_reg #(.TOGGLE_RULE(1'b0)) u_ctrl (
          .clk       (clk),
          .rst_n     (rst_n),
          .wr_hit    (wr_hit[i]),
          .wdata     (wdata),
          .set_loaded(1'b0),
          .set_pend  (1'b0),
          .clr_pend  (1'b0),
          .q         (regs[i]),
          .rst_pulse (eth_rst_pulse)
        );
      end else if (i == IDX_SCSI_ADDR) begin : g_scsi_addr
        twin_dma_addr_reg #(.XFER_W(XFER_W)) u_addr (
          .clk      (clk),
          .rst_n    (rst_n),
          .wr_hit   (wr_hit[i]),
          .wdata    (wdata),
          .adv      (xfer_fire),
          .adv_bytes(xfer_bytes),
          .q        (regs[i])
        );
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (!rst_n)         regs[i] <= '0;
          else if (wr_hit[i]) regs[i] <= wdata;
        end
      end
    end
  endgenerate

  twin_dma_irq_line u_scsi_line (
    .clk  (clk),
    .rst_n(rst_n),
    .raise(scsi_irq_raise),
    .drop (scsi_irq_clear | (wr_hit[IDX_SCSI_CTRL] & ~wdata[BIT_IE])),
    .line (scsi_irq)
  );

  twin_dma_irq_line u_eth_line (
    .clk  (clk),
    .rst_n(rst_n),
    .raise(eth_irq_raise),
    .drop (eth_irq_drop | (wr_hit[IDX_ETH_CTRL] & ~wdata[BIT_IE])),
    .line (eth_irq)
  );

  assign rdata = rd_en ? regs[idx] : '0;
endmodule

// File: rtl/twin_dma_csr_chk.sv
module twin_dma_csr_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              scsi_irq_raise,
  input logic              eth_irq_raise,
  input logic              scsi_irq,
  input logic              eth_irq,
  input logic              scsi_rst_pulse,
  input logic              eth_rst_pulse
);
  logic [2:0] cidx;
  assign cidx = addr[4:2];

  assert_version_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (cidx == 3'd0 || cidx == 3'd4)) |-> (rdata[31:28] == 4'hA));

  assert_scsi_ie_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cidx == 3'd0 && !wdata[4]) |=> !scsi_irq);

  assert_eth_ie_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cidx == 3'd4 && !wdata[4]) |=> !eth_irq);

  assert_scsi_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_rst_pulse |-> $past(wr_en && cidx == 3'd0 && wdata[7]));

  assert_eth_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eth_rst_pulse |-> $past(wr_en && cidx == 3'd4 && wdata[7]));

  assert_scsi_rise_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scsi_irq) |-> $past(scsi_irq_raise));

  assert_eth_rise_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eth_irq) |-> $past(eth_irq_raise));
endmodule

bind twin_dma_csr twin_dma_csr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/twin_dma_csr_test.sv
module twin_dma_csr_test;
  localparam int ADDR_W = 12;
  localparam int XFER_W = 16;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic xfer_valid = 1'b0, xfer_ready;
  logic [XFER_W-1:0] xfer_bytes = '0;
  logic scsi_irq_raise = 1'b0, scsi_irq_clear = 1'b0;
  logic eth_irq_raise = 1'b0, eth_irq_drop = 1'b0;
  logic scsi_irq, eth_irq, scsi_rst_pulse, eth_rst_pulse;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twin_dma_csr #(.ADDR_W(ADDR_W), .XFER_W(XFER_W)) uut (.*);

  localparam logic [31:0] V_WA [NV] = '{32'h000, 32'h000, 32'h000, 32'h000, 32'h000,
    32'h010, 32'h010, 32'h008, 32'h01C, 32'h024, 32'h03C, 32'h0B4, 32'h00C};
  localparam logic [31:0] V_WD [NV] = '{32'h0, 32'h40, 32'hC0, 32'hF0000010, 32'h50000000,
    32'h0, 32'h40, 32'hDEADBEEF, 32'h12345678, 32'h1000, 32'hCAFEF00D, 32'h0BADF00D, 32'h13579BDF};
  localparam logic [31:0] V_RA [NV] = '{32'h000, 32'h000, 32'h000, 32'h000, 32'h000,
    32'h010, 32'h010, 32'h008, 32'h01C, 32'h004, 32'h01C, 32'h014, 32'h00C};
  localparam logic [31:0] V_EX [NV] = '{32'hA0000040, 32'hA0000000, 32'hA00000C0, 32'hA0000010,
    32'hA0000000, 32'hA0000000, 32'hA0000040, 32'hDEADBEEF, 32'h12345678, 32'h1000,
    32'hCAFEF00D, 32'h0BADF00D, 32'h13579BDF};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[ADDR_W-1:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    addr = a[ADDR_W-1:0]; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
    #1;
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    case (which)
      0: scsi_irq_raise = 1'b1;
      1: scsi_irq_clear = 1'b1;
      2: begin scsi_irq_raise = 1'b1; scsi_irq_clear = 1'b1; end
      3: eth_irq_raise = 1'b1;
      default: eth_irq_drop = 1'b1;
    endcase
    @(negedge clk);
    scsi_irq_raise = 1'b0; scsi_irq_clear = 1'b0;
    eth_irq_raise = 1'b0; eth_irq_drop = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R2 R3 R4 R11: vector table
    for (int v = 0; v < NV; v++) begin
      do_write(V_WA[v], V_WD[v]);
      do_read(V_RA[v], r);
      check($sformatf("R2/R3/R4/R11 vector %0d", v), r, V_EX[v]);
    end

    // R1: reset state
    do_reset();
    for (int i = 0; i < 8; i++) begin
      do_read(32'(i * 4), r);
      check($sformatf("R1 index %0d", i), r, (i == 0 || i == 4) ? 32'hA0000000 : 32'h0);
    end
    check("R1 irq/pulse", {28'h0, scsi_irq, eth_irq, scsi_rst_pulse, eth_rst_pulse}, 32'h0);
    #1 check("R11 rdata idle", rdata, 32'h0);

    // R7: address write marks loaded
    do_write(32'h0, 32'h10);
    do_write(32'h4, 32'h100);
    do_read(32'h0, r); check("R7 loaded", r, 32'hA4000010);

    // R8: accepted event
    @(negedge clk); xfer_valid = 1'b1; xfer_bytes = 16'h20;
    @(negedge clk); xfer_valid = 1'b0;
    do_read(32'h4, r); check("R8 advance", r, 32'h120);
    do_read(32'h0, r); check("R8 pending", r, 32'hA4000011);
    check("R8 line untouched", {31'h0, scsi_irq}, 32'h0);

    // R8: back-pressure during address write
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h004; wdata = 32'h200; xfer_valid = 1'b1; xfer_bytes = 16'h10;
    #1 check("R8 ready low", {31'h0, xfer_ready}, 32'h0);
    @(negedge clk); wr_en = 1'b0;
    #1 check("R8 ready high", {31'h0, xfer_ready}, 32'h1);
    @(negedge clk); xfer_valid = 1'b0;
    do_read(32'h4, r); check("R8 held event", r, 32'h210);

    // R9 / R5: SCSI line
    do_write(32'h0, 32'h10);
    pulse_in(0);
    check("R9 raise line", {31'h0, scsi_irq}, 32'h1);
    do_read(32'h0, r); check("R9 raise bit", r, 32'hA0000011);
    do_write(32'h0, 32'h10);
    check("R5 ie kept", {31'h0, scsi_irq}, 32'h1);
    do_write(32'h0, 32'h0);
    check("R5 ie drop", {31'h0, scsi_irq}, 32'h0);
    do_read(32'h0, r); check("R4 zero write", r, 32'hA0000040);
    pulse_in(0);
    pulse_in(1);
    check("R9 clear line", {31'h0, scsi_irq}, 32'h0);
    do_read(32'h0, r); check("R9 clear bit", r, 32'hA0000040);
    pulse_in(2);
    check("R9 both line", {31'h0, scsi_irq}, 32'h0);
    do_read(32'h0, r); check("R9 both bit", r, 32'hA0000040);

    // R6: reset pulses
    do_write(32'h0, 32'h80);
    check("R6 scsi pulse", {30'h0, scsi_rst_pulse, eth_rst_pulse}, 32'h2);
    @(negedge clk);
    check("R6 scsi pulse end", {30'h0, scsi_rst_pulse, eth_rst_pulse}, 32'h0);
    do_write(32'h10, 32'h90);
    check("R6 eth pulse", {30'h0, scsi_rst_pulse, eth_rst_pulse}, 32'h1);
    @(negedge clk);
    check("R6 eth pulse end", {30'h0, scsi_rst_pulse, eth_rst_pulse}, 32'h0);

    // R10: Ethernet line
    pulse_in(3);
    check("R10 raise", {31'h0, eth_irq}, 32'h1);
    do_read(32'h10, r); check("R10 reg4 intact", r, 32'hA0000090);
    do_read(32'h0, r); check("R10 reg0 intact", r, 32'hA0000080);
    do_write(32'h10, 32'h10);
    check("R5 eth ie kept", {31'h0, eth_irq}, 32'h1);
    do_write(32'h10, 32'h0);
    check("R5 eth ie drop", {31'h0, eth_irq}, 32'h0);
    pulse_in(3);
    pulse_in(4);
    check("R10 drop", {31'h0, eth_irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule